// File: doc/BRIEF.md
# Prioritised Interrupt Hub with Claim and Completion

This block takes a set of external interrupt requests and spreads them over several hart contexts, where a context is one privilege level on one hardware thread. Each source passes through its own gateway, which turns a level or an edge into at most one outstanding request. The gateway then holds the source back while a handler owns it. Every source carries a programmable priority. Every context has its own set of enabled sources and a priority threshold, and drives one interrupt line.

A context takes the best waiting request by pulsing its claim input. One cycle later it reads the winning source number, and that request is then removed from the waiting set. When the handler is done, the context returns the same number on its completion port, and the gateway accepts requests from that source again. An edge source can be set to remember edges that arrive while its handler runs and replay them one per completion, or to drop them. Context slots can be built as absent, and an absent context takes no part in arbitration.

Top module: `irq_hub`

## Requirements
- R1: After reset every interrupt line and every returned claim number is 0, every priority, enable bitmap and threshold is 0, and every source is in level mode with edge dropping.
- R2: A source only reaches the contexts whose enable bitmap has that source's bit set, and a single source may be enabled in several contexts at once.
- R3: Among waiting sources enabled in a context, the highest priority value wins and equal priorities go to the lowest source number. Priority 0 never wins, and source number 0 means "none".
- R4: A context's line is high only when its winner's priority is greater than or equal to its threshold. A claim still returns the winner when the threshold hides it.
- R5: A claim request returns the winning number on the next cycle and removes that source's waiting request. With no winner it returns 0.
- R6: After a claim the source stays blocked until an accepted completion arrives. A level source still held high raises a new request right after completion.
- R7: A completion is accepted from any present context that has the source enabled, provided the source is currently claimed. A completion with any other number, or from a context without that source enabled, has no effect.
- R8: In queue mode, an edge source counts rising edges that arrive while it is claimed, up to QDEPTH (default 4) without wrapping. Each accepted completion turns one counted edge into a new request.
- R9: In drop mode, rising edges that arrive while an edge source is claimed are discarded.
- R10: A context marked absent in CTX_PRESENT (default: the highest slot) never raises its line, always returns 0 on claim, and never removes a waiting request.
- R11: When several contexts claim the same winner in one cycle, the lowest-numbered context receives it and the others receive 0.
- R12: Interrupt lines are registered. A source change sampled at clock edge k sets the gateway at edge k, and the line follows at edge k+1.
- R13: The register port uses address bits [7:5] to pick the region and [4:0] for the index. Region 0 holds the priority of the indexed source in data bits [PRIO_W-1:0]. Region 1 holds two bitmaps: index 0 is edge mode and index 1 is queue mode, with bit s for source s. Region 2 holds the enable bitmap of the indexed context, and region 3 holds that context's threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Source requests, bit s-1 is source s |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| claim_req_i | input | N_CTX | Claim pulse per context |
| cmp_req_i | input | N_CTX | Completion pulse per context |
| cmp_id_i | input | N_CTX*IDW | Completed source number per context |
| irq_o | output | N_CTX | Registered interrupt line per context |
| claim_id_o | output | N_CTX*IDW | Claimed source number per context, updated on claim |

## Verification
Two contexts can claim in the same cycle. The bench enables one source in both contexts, raises it, and pulses both claim inputs on one edge. It then checks that the lower context reads the source number and the upper one reads 0. The same source is then completed from the upper context and raised again. A fresh interrupt shows that the completion was accepted and that the shared claim left the source in a single consistent blocked state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    RG_PRIO   = 3'd0,
    RG_MODE   = 3'd1,
    RG_ENABLE = 3'd2,
    RG_THRESH = 3'd3
  } cfg_region_e;

  localparam int MODE_IDX_EDGE  = 0;
  localparam int MODE_IDX_QUEUE = 1;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = 10,
  parameter int N_CTX  = 3,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [N_SRC:0][PRIO_W-1:0]      prio_o,
  output logic [N_SRC:0]                  edge_o,
  output logic [N_SRC:0]                  queue_o,
  output logic [N_CTX-1:0][N_SRC:0]       en_o,
  output logic [N_CTX-1:0][PRIO_W-1:0]    thr_o
);
  localparam int IDX_W = ADDR_W - REGION_W;

  cfg_region_e      region;
  logic [IDX_W-1:0] idx;
  logic             cfg_unused_bits;

  assign region          = cfg_region_e'(addr[ADDR_W-1 -: REGION_W]);
  assign idx             = addr[IDX_W-1:0];
  assign cfg_unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_o  <= '0;
      edge_o  <= '0;
      queue_o <= '0;
      en_o    <= '0;
      thr_o   <= '0;
    end else if (we) begin
      case (region)
        RG_PRIO: begin
          for (int s = 1; s <= N_SRC; s++)
            if (idx == IDX_W'(s)) prio_o[s] <= wdata[PRIO_W-1:0];
        end
        RG_MODE: begin
          if (idx == IDX_W'(MODE_IDX_EDGE))  edge_o  <= {wdata[N_SRC:1], 1'b0};
          if (idx == IDX_W'(MODE_IDX_QUEUE)) queue_o <= {wdata[N_SRC:1], 1'b0};
        end
        RG_ENABLE: begin
          for (int c = 0; c < N_CTX; c++)
            if (idx == IDX_W'(c)) en_o[c] <= {wdata[N_SRC:1], 1'b0};
        end
        RG_THRESH: begin
          for (int c = 0; c < N_CTX; c++)
            if (idx == IDX_W'(c)) thr_o[c] <= wdata[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int QDEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic queue_mode_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic active_o
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             has_q;
  logic             room;

  assign rise  = src_i & ~prev_q;
  assign has_q = (cnt_q != '0);
  assign room  = (cnt_q != CNT_W'(QDEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      cnt_q    <= '0;
      pend_o   <= 1'b0;
      active_o <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (!edge_mode_i) begin
        cnt_q <= '0;
        if (claim_i) begin
          pend_o   <= 1'b0;
          active_o <= 1'b1;
        end else if (complete_i) begin
          active_o <= 1'b0;
          pend_o   <= src_i;
        end else begin
          pend_o <= src_i & ~active_o;
        end
      end else begin
        if (claim_i) begin
          pend_o   <= 1'b0;
          active_o <= 1'b1;
          if (rise && queue_mode_i && room) cnt_q <= cnt_q + 1'b1;
        end else if (complete_i) begin
          active_o <= 1'b0;
          pend_o   <= has_q | rise;
          if (has_q && !(rise && queue_mode_i)) cnt_q <= cnt_q - 1'b1;
        end else if (active_o) begin
          if (rise && queue_mode_i && room) cnt_q <= cnt_q + 1'b1;
        end else if (rise) begin
          pend_o <= 1'b1;
        end
      end
    end
  end

  AST_PEND_ACTIVE_EXCL: assert property (@(posedge clk) disable iff (rst) !(pend_o && active_o)); // R6
  AST_HELD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst) (active_o && !complete_i) |=> active_o); // R6
  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst) claim_i |=> (active_o && !pend_o)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_W'(QDEPTH)); // R8
  AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (rst) !queue_mode_i |=> cnt_q <= $past(cnt_q)); // R9
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int N_SRC  = 10,
  parameter int PRIO_W = 3,
  parameter int IDW    = 4
) (
  input  logic [N_SRC:0]             elig_i,
  input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
  output logic [IDW-1:0]             win_id_o,
  output logic [PRIO_W-1:0]          win_prio_o
);
  logic arb_unused_bits;
  assign arb_unused_bits = elig_i[0] ^ (^prio_i[0]);

  always_comb begin
    win_id_o   = '0;
    win_prio_o = '0;
    for (int s = N_SRC; s >= 1; s--) begin
      if (elig_i[s] && (prio_i[s] != '0) && (prio_i[s] >= win_prio_o)) begin
        win_id_o   = IDW'(s);
        win_prio_o = prio_i[s];
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int               N_SRC       = 10,
  parameter int               N_CTX       = 3,
  parameter int               PRIO_W      = 3,
  parameter int               QDEPTH      = 4,
  parameter int               ADDR_W      = 8,
  parameter int               DATA_W      = 32,
  parameter logic [N_CTX-1:0] CTX_PRESENT = {1'b0, {(N_CTX-1){1'b1}}},
  localparam int              IDW         = $clog2(N_SRC + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_SRC:1]             src_i,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  input  logic [N_CTX-1:0]           claim_req_i,
  input  logic [N_CTX-1:0]           cmp_req_i,
  input  logic [N_CTX-1:0][IDW-1:0]  cmp_id_i,
  output logic [N_CTX-1:0]           irq_o,
  output logic [N_CTX-1:0][IDW-1:0]  claim_id_o
);
  localparam int NV = 1 << IDW;

  logic [N_SRC:0][PRIO_W-1:0]    prio_c;
  logic [N_SRC:0]                edge_c, queue_c;
  logic [N_CTX-1:0][N_SRC:0]     en_c;
  logic [N_CTX-1:0][PRIO_W-1:0]  thr_c;

  logic [N_SRC:0]                pend, act;
  logic [NV-1:0]                 pend_v, act_v;
  logic [N_CTX-1:0][NV-1:0]      en_v;
  logic [NV-1:0]                 src_claim, src_cmp;
  logic [N_CTX-1:0]              grant, irq_d;
  logic [N_CTX-1:0][IDW-1:0]     win_id;
  logic [N_CTX-1:0][PRIO_W-1:0]  win_prio;
  logic                          hub_unused_bits;

  irq_cfg_regs #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio_o(prio_c), .edge_o(edge_c), .queue_o(queue_c), .en_o(en_c), .thr_o(thr_c)
  );

  assign pend[0] = 1'b0;
  assign act[0]  = 1'b0;

  for (genvar s = 1; s <= N_SRC; s++) begin : g_src
    irq_gateway #(.QDEPTH(QDEPTH)) u_gw (
      .clk(clk), .rst(rst), .src_i(src_i[s]),
      .edge_mode_i(edge_c[s]), .queue_mode_i(queue_c[s]),
      .claim_i(src_claim[s]), .complete_i(src_cmp[s]),
      .pend_o(pend[s]), .active_o(act[s])
    );
  end

  assign pend_v = NV'(pend);
  assign act_v  = NV'(act);
  assign hub_unused_bits = ^{src_claim, src_cmp, edge_c[0], queue_c[0]};

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    assign en_v[c] = NV'(en_c[c]);

    irq_ctx_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .elig_i(pend & en_c[c]), .prio_i(prio_c),
      .win_id_o(win_id[c]), .win_prio_o(win_prio[c])
    );

    assign irq_d[c] = CTX_PRESENT[c] && (win_id[c] != '0) && (win_prio[c] >= thr_c[c]);

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
      (win_id[c] != '0) |-> (pend_v[win_id[c]] && en_v[c][win_id[c]])); // R3
    if (!CTX_PRESENT[c]) begin : g_absent
      AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (rst)
        !irq_o[c] && (claim_id_o[c] == '0)); // R10
    end
  end

  // Lower context indices are served first; a source granted once this cycle is skipped.
  always_comb begin
    src_claim = '0;
    grant     = '0;
    for (int c = 0; c < N_CTX; c++) begin
      if (claim_req_i[c] && CTX_PRESENT[c] && (win_id[c] != '0) && !src_claim[win_id[c]]) begin
        grant[c]             = 1'b1;
        src_claim[win_id[c]] = 1'b1;
      end
    end
  end

  always_comb begin
    src_cmp = '0;
    for (int c = 0; c < N_CTX; c++) begin
      if (cmp_req_i[c] && CTX_PRESENT[c] && (cmp_id_i[c] != '0) &&
          act_v[cmp_id_i[c]] && en_v[c][cmp_id_i[c]])
        src_cmp[cmp_id_i[c]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= '0;
      claim_id_o <= '0;
    end else begin
      irq_o <= irq_d;
      for (int c = 0; c < N_CTX; c++)
        if (claim_req_i[c]) claim_id_o[c] <= grant[c] ? win_id[c] : '0;
    end
  end

  AST_CLAIM_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) (src_claim & ~pend_v) == '0); // R5
  AST_CMP_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst) (src_cmp & ~act_v) == '0); // R7
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int NS = 10;
  localparam int NC = 3;
  localparam int IW = 4;

  typedef struct packed {
    logic [NS:0] mask;
    logic [2:0]  thr;
    logic        irq;
    logic [3:0]  id;
  } vec_t;

  // Priorities used below: s1=2 s2=5 s3=5 s4=0 s5=7 s6=1 s7=3 s8=3 s9=6 s10=2
  localparam int PR[NS+1] = '{0, 2, 5, 5, 0, 7, 1, 3, 3, 6, 2};
  localparam vec_t VEC[10] = '{
    '{11'h002, 3'd0, 1'b1, 4'd1},
    '{11'h00C, 3'd0, 1'b1, 4'd2},
    '{11'h010, 3'd0, 1'b0, 4'd0},
    '{11'h220, 3'd7, 1'b1, 4'd5},
    '{11'h200, 3'd7, 1'b0, 4'd9},
    '{11'h580, 3'd1, 1'b1, 4'd7},
    '{11'h040, 3'd2, 1'b0, 4'd6},
    '{11'h000, 3'd0, 1'b0, 4'd0},
    '{11'h442, 3'd0, 1'b1, 4'd1},
    '{11'h7FE, 3'd0, 1'b1, 4'd5}
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NS:1]            src = '0;
  logic                   cfg_we = 1'b0;
  logic [7:0]             cfg_addr = '0;
  logic [31:0]            cfg_wdata = '0;
  logic [NC-1:0]          claim_req = '0;
  logic [NC-1:0]          cmp_req = '0;
  logic [NC-1:0][IW-1:0]  cmp_id = '0;
  logic [NC-1:0]          irq;
  logic [NC-1:0][IW-1:0]  claim_id;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst(rst), .src_i(src), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .claim_req_i(claim_req), .cmp_req_i(cmp_req),
    .cmp_id_i(cmp_id), .irq_o(irq), .claim_id_o(claim_id)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic claim(int c);
    claim_req[c] = 1'b1;
    step(1);
    claim_req[c] = 1'b0;
  endtask

  task automatic cmpl(int c, int id);
    cmp_req[c] = 1'b1; cmp_id[c] = IW'(id);
    step(1);
    cmp_req[c] = 1'b0;
  endtask

  task automatic pulse(int s);
    src[s] = 1'b1; step(1);
    src[s] = 1'b0; step(1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    chk("R1 irq lines after reset", int'(irq), 0);
    chk("R1 claim numbers after reset", int'(claim_id), 0);
    wr(8'h40, 32'h7FE);
    src[1] = 1'b1; step(3);
    chk("R1 R3 reset priority 0 never interrupts", int'(irq[0]), 0);
    src = '0; step(2);
    for (int s = 1; s <= NS; s++) wr(s, PR[s]);

    // Table walk, context 0 enables all sources, context 1 none
    for (int i = 0; i < 10; i++) begin
      wr(8'h60, int'(VEC[i].thr));
      src = VEC[i].mask[NS:1];
      step(3);
      chk($sformatf("R4 row %0d irq", i), int'(irq[0]), int'(VEC[i].irq));
      chk($sformatf("R2 row %0d unenabled context quiet", i), int'(irq[1]), 0);
      claim(0);
      chk($sformatf("R3 R5 row %0d claimed number", i), int'(claim_id[0]), int'(VEC[i].id));
      if (VEC[i].id != 0) cmpl(0, int'(VEC[i].id));
      src = '0; step(3);
    end
    wr(8'h60, 0);

    // R12 latency
    src[1] = 1'b1; step(1);
    chk("R12 line not yet high one edge after source", int'(irq[0]), 0);
    step(1);
    chk("R12 line high two edges after source", int'(irq[0]), 1);
    claim(0);
    chk("R5 claim returns source 1", int'(claim_id[0]), 1);
    step(1);
    chk("R5 line drops after claim", int'(irq[0]), 0);
    src[1] = 1'b0; cmpl(0, 1); step(3);

    // R6 R7 level source blocked until proper completion
    wr(8'h41, 32'h008);
    src[2] = 1'b1; step(3);
    claim(0);
    chk("R6 claim source 2", int'(claim_id[0]), 2);
    step(2);
    chk("R6 held level blocked while claimed", int'(irq[0]), 0);
    cmpl(0, 3); step(3);
    chk("R7 completion of unclaimed number ignored", int'(irq[0]), 0);
    cmpl(1, 2); step(3);
    chk("R7 completion from context without enable ignored", int'(irq[0]), 0);
    cmpl(0, 2); step(3);
    chk("R6 level re-requests after completion", int'(irq[0]), 1);
    claim(0); src[2] = 1'b0; cmpl(0, 2); step(3);

    // R2 per-context enable
    src[5] = 1'b1; step(3);
    chk("R2 context 1 ignores source 5", int'(irq[1]), 0);
    src[5] = 1'b0; src[3] = 1'b1; step(3);
    chk("R2 context 1 sees enabled source 3", int'(irq[1]), 1);
    chk("R2 context 0 also sees source 3", int'(irq[0]), 1);
    claim(1);
    chk("R2 context 1 claims 3", int'(claim_id[1]), 3);
    cmpl(1, 3); src[3] = 1'b0; step(3);

    // R11 simultaneous claims
    wr(8'h41, 32'h7FE);
    src[5] = 1'b1; step(3);
    claim_req = 3'b011; step(1); claim_req = '0;
    chk("R11 lower context wins shared claim", int'(claim_id[0]), 5);
    chk("R11 upper context gets 0", int'(claim_id[1]), 0);
    src[5] = 1'b0; cmpl(1, 5); step(3);
    src[5] = 1'b1; step(3);
    chk("R7 completion from other enabled context accepted", int'(irq[0]), 1);
    claim(0); src[5] = 1'b0; cmpl(0, 5); step(3);
    wr(8'h41, 0);

    // R10 absent context
    wr(8'h42, 32'h7FE);
    src[1] = 1'b1; step(3);
    chk("R10 absent context line low", int'(irq[2]), 0);
    claim(2);
    chk("R10 absent context claims 0", int'(claim_id[2]), 0);
    claim(0);
    chk("R10 request left for present context", int'(claim_id[0]), 1);
    src[1] = 1'b0; cmpl(0, 1); step(3);

    // R13 register map: priority of source 10 at address 0x0A
    wr(8'h0A, 0);
    src[10] = 1'b1; step(3);
    chk("R13 source 10 priority 0 silent", int'(irq[0]), 0);
    wr(8'h0A, 7); step(2);
    chk("R13 source 10 priority 7 raises line", int'(irq[0]), 1);
    claim(0);
    chk("R13 claim source 10", int'(claim_id[0]), 10);
    src[10] = 1'b0; cmpl(0, 10); step(3);

    // R8 queued edges with saturation
    wr(8'h20, 32'h00C);
    wr(8'h21, 32'h008);
    pulse(3); step(2);
    chk("R8 edge raises line", int'(irq[0]), 1);
    claim(0);
    chk("R8 claim edge source 3", int'(claim_id[0]), 3);
    for (int k = 0; k < 6; k++) pulse(3);
    cmpl(0, 3);
    for (int r = 0; r < 4; r++) begin
      step(2);
      claim(0);
      chk($sformatf("R8 replay %0d", r), int'(claim_id[0]), 3);
      cmpl(0, 3);
    end
    step(2);
    claim(0);
    chk("R8 queue saturated at four", int'(claim_id[0]), 0);
    chk("R8 no line after queue drained", int'(irq[0]), 0);

    // R9 dropped edges
    pulse(2); step(2);
    claim(0);
    chk("R9 claim edge source 2", int'(claim_id[0]), 2);
    for (int k = 0; k < 3; k++) pulse(2);
    cmpl(0, 2); step(2);
    claim(0);
    chk("R9 edges during handler dropped", int'(claim_id[0]), 0);
    chk("R9 line stays low", int'(irq[0]), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule